// File: doc/BRIEF.md
# Carry-Skip Adder with Registered Result Stream

This block adds two N-bit unsigned operands and a carry-in, producing an N-bit sum and a carry-out. The operand word is split into equal groups of M bits. Inside a group the carry ripples bit by bit from per-bit propagate (XOR of the operand bits) and generate (AND of the operand bits) terms. Each group also forms the AND of its propagate terms. When that AND is true, a 2:1 multiplexer passes the group's carry-in straight to its carry-out and bypasses the ripple path. Otherwise the group's carry-out is the ripple result. The carry-out of the last group is the adder's carry-out.

Operands enter through a valid/ready handshake, and the result leaves through one. The adder core is purely combinational. Its result is captured in a one-entry output register. A transfer on the input side happens on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a new result can replace the one leaving without a bubble. While the consumer holds `out_ready` low on a valid result, the result stays frozen and no new operands are taken. A source may hold `in_valid` high for as long as it wants; the transfer happens only when `in_ready` is high.

Top module: `csk_adder`

## Requirements
- R1: For every accepted operand set, the registered result satisfies {cout, sum} = a + b + cin, with all values unsigned and N+1 bits wide.
- R2: `out_valid` is high in the cycle after an input handshake, and `sum`/`cout` then hold that handshake's result.
- R3: `in_ready` equals the expression (not `out_valid`) or `out_ready`.
- R4: While `out_valid` is high and `out_ready` is low, `sum`, `cout` and `out_valid` keep their values on the next edge. Operands offered during that time are not taken.
- R5: After reset, `out_valid` is low and `in_ready` is high.
- R6: When every bit pair differs (a XOR b is all ones), every group takes its bypass. The result is then `sum` = all bits equal to the inverse of cin, and `cout` = cin.
- R7: A carry generated inside one group reaches the next group through the ripple path whenever that group does not fully propagate. One example is a = 0x0000000F with b = 0x00000001, where the carry crosses from the lowest group into the next.
- R8: If the output register is drained (`out_valid` and `out_ready` high) and no input handshake happens, `out_valid` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on a, b, cin are offered |
| in_ready | output | 1 | Adder can take operands this cycle |
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | sum/cout hold a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| sum | output | N | Registered sum |
| cout | output | 1 | Registered carry out of the last group |

## Verification
Each result appears exactly one clock edge after the handshake that carried its operands. `in_ready` is a same-cycle function of `out_valid` and `out_ready`. The bench therefore changes inputs on the falling edge and checks at the following falling edge. This puts exactly one capturing rising edge between stimulus and check. In the stall sequence, the held result is checked on the falling edge after each stalled rising edge. The replacement result is checked one edge after `out_ready` returns high.

// File: rtl/csk_pkg.sv
package csk_pkg;
  function automatic int group_count(input int width, input int grp);
    return width / grp;
  endfunction
endpackage

// File: rtl/csk_group.sv
module csk_group #(
  parameter int M = 4
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  input  logic         ci,
  output logic [M-1:0] s,
  output logic         co
);
  logic [M-1:0] prop;
  logic [M-1:0] gen;
  logic [M:0]   rc;
  logic         all_prop;

  assign rc[0] = ci;

  for (genvar i = 0; i < M; i++) begin : g_bit
    assign prop[i]  = a[i] ^ b[i];
    assign gen[i]   = a[i] & b[i];
    assign rc[i+1]  = gen[i] | (prop[i] & rc[i]);
    assign s[i]     = rc[i] ^ prop[i];
  end

  assign all_prop = &prop;
  // bypass mux: group carry-in forwarded when every bit propagates
  assign co = all_prop ? ci : rc[M];
endmodule

// File: rtl/csk_core.sv
module csk_core
  import csk_pkg::*;
#(
  parameter int N = 32,
  parameter int M = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam int NG = group_count(N, M);

  logic [NG:0] gc;
  assign gc[0] = cin;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    csk_group #(.M(M)) u_grp (
      .a  (a[g*M +: M]),
      .b  (b[g*M +: M]),
      .ci (gc[g]),
      .s  (sum[g*M +: M]),
      .co (gc[g+1])
    );
  end

  assign cout = gc[NG];
endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
  parameter int N = 32,
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N-1:0] core_sum;
  logic         core_cout;
  logic         take;

  csk_core #(.N(N), .M(M)) u_core (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (core_sum),
    .cout (core_cout)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      cout      <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        sum       <= core_sum;
        cout      <= core_cout;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic         cin,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] sum,
  input logic         cout
);
  logic hs;
  assign hs = in_valid && in_ready;

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{N{1'b0}}, $past(cin)})));

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> out_valid);

  // R3
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(sum) && $stable(cout)));

  // R6
  full_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && ((a ^ b) == {N{1'b1}})) |=> (sum == {N{!$past(cin)}} && cout == $past(cin)));

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind csk_adder csk_adder_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .a         (a),
  .b         (b),
  .cin       (cin),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .sum       (sum),
  .cout      (cout)
);

// File: tb/tb_csk_adder.sv
module tb_csk_adder;
  localparam int CLK_P = 10;
  localparam int N = 32;
  localparam int NV = 12;
  // each entry: {cin, a, b}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 32'h0000_000F, 32'h0000_0001},  // R7 carry crosses group 0
    {1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b1, 32'h5555_5555, 32'hAAAA_AAAA},  // R6 all groups bypass
    {1'b0, 32'h5555_5555, 32'hAAAA_AAAA},  // R6
    {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
    {1'b1, 32'hF0F0_F0F0, 32'h0F0F_0F0F},  // R6
    {1'b0, 32'h0FFF_FFF0, 32'h0000_0010},  // R7 ripple then skips
    {1'b1, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 32'hDEAD_BEEF, 32'h2152_4110}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic         cin = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [N-1:0] sum;
  logic         cout;

  int nvec = 0;
  int nmis = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  csk_adder #(.N(N), .M(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .cin(cin), .out_valid(out_valid), .out_ready(out_ready),
    .sum(sum), .cout(cout)
  );

  function automatic logic [N:0] ref_add(input logic [N-1:0] x, input logic [N-1:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
  endfunction

  task automatic check(input string req, input logic [N:0] act, input logic [N:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    nvec++;
    nmis++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [N:0] x_exp;
    logic [N:0] y_exp;
    #(CLK_P * 2 + 1);
    // R5 reset state
    check("R5", {{(N-1){1'b0}}, out_valid, in_ready}, {{(N-1){1'b0}}, 1'b0, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5", {{(N-1){1'b0}}, out_valid, in_ready}, {{(N-1){1'b0}}, 1'b0, 1'b1});

    // table walk: R1, R2, R6, R7
    for (int i = 0; i < NV; i++) begin
      cin = VEC[i][64]; a = VEC[i][63:32]; b = VEC[i][31:0];
      in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      check("R2", {{N{1'b0}}, out_valid}, {{N{1'b0}}, 1'b1});
      check("R1", {cout, sum}, ref_add(VEC[i][63:32], VEC[i][31:0], VEC[i][64]));
    end

    // R8 drain with no new input
    in_valid = 1'b0;
    @(negedge clk);
    check("R8", {{N{1'b0}}, out_valid}, {{N{1'b0}}, 1'b0});

    // R4 / R3 back-pressure
    out_ready = 1'b0;
    a = 32'h0000_00FF; b = 32'h0000_0101; cin = 1'b0; in_valid = 1'b1;
    x_exp = ref_add(a, b, cin);
    @(negedge clk);
    check("R2", {cout, sum}, x_exp);
    a = 32'h7777_7777; b = 32'h1111_1111; cin = 1'b1;
    y_exp = ref_add(a, b, cin);
    check("R3", {{N{1'b0}}, in_ready}, {{N{1'b0}}, 1'b0});
    @(negedge clk);
    check("R4", {cout, sum}, x_exp);
    check("R4", {{N{1'b0}}, out_valid}, {{N{1'b0}}, 1'b1});
    @(negedge clk);
    check("R4", {cout, sum}, x_exp);
    out_ready = 1'b1;
    #1;
    check("R3", {{N{1'b0}}, in_ready}, {{N{1'b0}}, 1'b1});
    @(negedge clk);
    check("R1", {cout, sum}, y_exp);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8", {{N{1'b0}}, out_valid}, {{N{1'b0}}, 1'b0});

    // R6 directed: a ^ b all ones, both carry-in values
    a = 32'hC3A5_0F96; b = ~32'hC3A5_0F96; cin = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R6", {cout, sum}, {1'b1, {N{1'b0}}});
    cin = 1'b0;
    @(negedge clk);
    check("R6", {cout, sum}, {1'b0, {N{1'b1}}});
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule